// File: doc/BRIEF.md
# Processor Status Word Register with Branch Condition Evaluator

This block keeps the processor status word: a trace bit, a supervisor bit, a three-bit interrupt priority mask and five condition flags (extend, negative, zero, overflow, carry). The flags are packed into a sparse 16-bit word. Bits that have no field behind them are not stored and always read as zero. Each clock the register can take at most one update, chosen by a 3-bit operation code. The update can load the whole word, load only the low condition-code byte, or merge a 16-bit immediate into the stored fields with AND, OR or XOR.

A second, purely combinational path reads a 4-bit selector and reports whether the chosen branch condition holds for the flags currently stored. It covers the signed and unsigned comparisons a branch unit needs.

The update port is a plain control input with no valid/ready handshake. An operation code of "none" is the idle state, and the register never applies back-pressure, so every update presented is taken on the next rising edge. The word output and the condition output are status pins and are always valid.

Top module: `psw_core`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low) and after its release, the word reads 0x2700 until the first update: supervisor is 1, the mask is 7 and every other field is 0.
- R2: Field positions in `psw_word` are: trace at bit 15, supervisor at bit 13, mask at 10:8, extend at 4, negative at 3, zero at 2, overflow at 1 and carry at 0. Bits 14, 12, 11 and 7:5 always read 0, whatever is written to them.
- R3: `upd_op`=1 (full load) replaces every implemented field with the matching bits of `upd_word`. The result appears on `psw_word` after the next rising edge.
- R4: `upd_op`=2 (condition-code load) copies `upd_word[4:0]` into extend, negative, zero, overflow and carry. Trace, supervisor and the mask keep their values.
- R5: `upd_op`=3 ANDs each implemented field with the matching operand bits. The mask is combined as a 3-bit value.
- R6: `upd_op`=4 ORs each implemented field with the matching operand bits.
- R7: `upd_op`=5 XORs each implemented field with the matching operand bits.
- R8: `upd_op` values 0, 6 and 7 leave the word unchanged.
- R9: For `cond_sel` 0 to 7, `cond_true` gives, in order: true; false; HI (C=0 and Z=0); LS (C=1 or Z=1); CC (C=0); CS (C=1); NE (Z=0); EQ (Z=1).
- R10: For `cond_sel` 8 to 15, `cond_true` gives, in order: VC (V=0); VS (V=1); PL (N=0); MI (N=1); GE (N=V); LT (N!=V); GT (N=V and Z=0); LE (Z=1 or N!=V).
- R11: `cond_true` depends only on the stored word. An update presented in the same cycle does not affect it until after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_op | input | 3 | Update select: 0 none, 1 full load, 2 condition-code load, 3 AND, 4 OR, 5 XOR, 6/7 none |
| upd_word | input | 16 | Operand for the selected update |
| cond_sel | input | 4 | Branch condition selector |
| psw_word | output | 16 | Packed status word, reserved bits zero |
| cond_true | output | 1 | Selected condition holds for the stored flags |

## Verification
A corrupted stored field shows up on `psw_word` in the cycle after the edge that wrote it, because the word is a direct repacking of the register with no extra stage. A wrong flag also changes `cond_true` in that same cycle for every selector that reads that flag. The bench therefore sweeps all 32 flag combinations against all 16 selectors, so that a swapped or inverted term in the decoder cannot hide. A reserved bit that leaks through, or a mask bit merged in the wrong way, shows as a word miscompare one cycle after the offending update.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int WORD_W = 16;
  localparam int MASK_W = 3;
  localparam int SEL_W  = 4;
  localparam int OP_W   = 3;
  localparam int CCR_W  = 5;

  localparam int POS_T  = 15;
  localparam int POS_S  = 13;
  localparam int POS_IM = 8;
  localparam int POS_X  = 4;
  localparam int POS_N  = 3;
  localparam int POS_Z  = 2;
  localparam int POS_V  = 1;
  localparam int POS_C  = 0;

  localparam logic [WORD_W-1:0] RESET_WORD = 16'h2700;

  typedef enum logic [OP_W-1:0] {
    UPD_NONE = 3'd0,
    UPD_LOAD = 3'd1,
    UPD_CCR  = 3'd2,
    UPD_AND  = 3'd3,
    UPD_OR   = 3'd4,
    UPD_XOR  = 3'd5
  } upd_op_e;

  typedef struct packed {
    logic              trc;
    logic              sup;
    logic [MASK_W-1:0] ipm;
    logic              ext;
    logic              neg;
    logic              zer;
    logic              ovf;
    logic              cry;
  } psw_t;

  function automatic psw_t unpack_word(input logic [WORD_W-1:0] w);
    psw_t r;
    r.trc = w[POS_T];
    r.sup = w[POS_S];
    r.ipm = w[POS_IM +: MASK_W];
    r.ext = w[POS_X];
    r.neg = w[POS_N];
    r.zer = w[POS_Z];
    r.ovf = w[POS_V];
    r.cry = w[POS_C];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input psw_t p);
    logic [WORD_W-1:0] w;
    w = '0;
    w[POS_T] = p.trc;
    w[POS_S] = p.sup;
    w[POS_IM +: MASK_W] = p.ipm;
    w[POS_X] = p.ext;
    w[POS_N] = p.neg;
    w[POS_Z] = p.zer;
    w[POS_V] = p.ovf;
    w[POS_C] = p.cry;
    return w;
  endfunction
endpackage

// File: rtl/psw_next.sv
module psw_next
  import psw_pkg::*;
(
  input  psw_t              cur,
  input  logic [OP_W-1:0]   op,
  input  logic [WORD_W-1:0] operand,
  output psw_t              nxt
);
  psw_t opnd;
  assign opnd = unpack_word(operand);

  always_comb begin
    nxt = cur;
    unique case (op)
      UPD_LOAD: nxt = opnd;
      UPD_CCR: begin
        nxt.ext = opnd.ext;
        nxt.neg = opnd.neg;
        nxt.zer = opnd.zer;
        nxt.ovf = opnd.ovf;
        nxt.cry = opnd.cry;
      end
      UPD_AND: nxt = cur & opnd;
      UPD_OR:  nxt = cur | opnd;
      UPD_XOR: nxt = cur ^ opnd;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/psw_cond.sv
module psw_cond
  import psw_pkg::*;
(
  input  psw_t             flags,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam int NCOND = 1 << SEL_W;
  logic [NCOND-1:0] tbl;
  logic sgn_ok;

  assign sgn_ok = ~(flags.neg ^ flags.ovf);

  always_comb begin
    tbl     = '0;
    tbl[0]  = 1'b1;
    tbl[1]  = 1'b0;
    tbl[2]  = ~flags.cry & ~flags.zer;
    tbl[3]  = flags.cry | flags.zer;
    tbl[4]  = ~flags.cry;
    tbl[5]  = flags.cry;
    tbl[6]  = ~flags.zer;
    tbl[7]  = flags.zer;
    tbl[8]  = ~flags.ovf;
    tbl[9]  = flags.ovf;
    tbl[10] = ~flags.neg;
    tbl[11] = flags.neg;
    tbl[12] = sgn_ok;
    tbl[13] = ~sgn_ok;
    tbl[14] = sgn_ok & ~flags.zer;
    tbl[15] = flags.zer | ~sgn_ok;
  end

  assign hit = tbl[sel];
endmodule

// File: rtl/psw_core.sv
module psw_core
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        upd_op,
  input  logic [15:0]       upd_word,
  input  logic [3:0]        cond_sel,
  output logic [15:0]       psw_word,
  output logic              cond_true
);
  psw_t state_q;
  psw_t state_d;

  psw_next u_next (
    .cur     (state_q),
    .op      (upd_op),
    .operand (upd_word),
    .nxt     (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= unpack_word(RESET_WORD);
    else        state_q <= state_d;
  end

  psw_cond u_cond (
    .flags (state_q),
    .sel   (cond_sel),
    .hit   (cond_true)
  );

  assign psw_word = pack_word(state_q);
endmodule

// File: rtl/psw_core_chk.sv
module psw_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  upd_op,
  input logic [15:0] upd_word,
  input logic [3:0]  cond_sel,
  input logic [15:0] psw_word,
  input logic        cond_true
);
  localparam logic [15:0] LIVE = 16'hA71F;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_word & ~LIVE) == 16'h0000);

  a_r3_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd_op == 3'd1 |=> psw_word == ($past(upd_word) & LIVE));

  a_r4_ccr_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    upd_op == 3'd2 |=> (psw_word[15:5] == $past(psw_word[15:5])) &&
                       (psw_word[4:0] == $past(upd_word[4:0])));

  a_r7_xor_merge: assert property (@(posedge clk) disable iff (!rst_n)
    upd_op == 3'd5 |=> psw_word == ($past(psw_word) ^ ($past(upd_word) & LIVE)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_op == 3'd0 || upd_op >= 3'd6) |=> $stable(psw_word));

  a_r9_const_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd0 |-> cond_true) and (cond_sel == 4'd1 |-> !cond_true));
endmodule

bind psw_core psw_core_chk u_chk (.*);

// File: tb/sim_psw_core.sv
module sim_psw_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  upd_op = 3'd0;
  logic [15:0] upd_word = 16'h0;
  logic [3:0]  cond_sel = 4'd0;
  logic [15:0] psw_word;
  logic        cond_true;

  localparam logic [15:0] LIVE = 16'hA71F;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] model = 16'h2700;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  psw_core u0 (.*);

  function automatic logic ref_cond(input logic [15:0] w, input logic [3:0] s);
    logic c, v, z, n;
    c = w[0]; v = w[1]; z = w[2]; n = w[3];
    case (s)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return !(c || z);
      4'd3:  return c || z;
      4'd4:  return !c;
      4'd5:  return c;
      4'd6:  return !z;
      4'd7:  return z;
      4'd8:  return !v;
      4'd9:  return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return n == v;
      4'd13: return n != v;
      4'd14: return (n == v) && !z;
      default: return z || (n != v);
    endcase
  endfunction

  function automatic logic [15:0] ref_next(input logic [15:0] w, input logic [2:0] op,
                                           input logic [15:0] d);
    case (op)
      3'd1: return d & LIVE;
      3'd2: return {w[15:5], d[4:0]};
      3'd3: return w & d & LIVE;
      3'd4: return (w | d) & LIVE;
      3'd5: return (w ^ d) & LIVE;
      default: return w;
    endcase
  endfunction

  task automatic report(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  // driver: presents one update and selector, checks the same-cycle condition
  // against the pre-update model (R11), queues the expected word
  task automatic drive(input logic [2:0] op, input logic [15:0] d, input logic [3:0] sel,
                       input string tag);
    @(negedge clk);
    upd_op = op; upd_word = d; cond_sel = sel;
    #1;
    report({tag, " cond"}, {15'b0, cond_true}, {15'b0, ref_cond(model, sel)});
    model = ref_next(model, op, d);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // monitor: compares the word one edge after each update
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (exp_q.size() > 0) report({tag_q.pop_front(), " word"}, psw_word, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    report("R1 in reset", psw_word, 16'h2700);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    report("R1 after release", psw_word, 16'h2700);

    drive(3'd1, 16'hFFFF, 4'd0, "R2 R3 load all ones");
    drive(3'd1, 16'h58E0, 4'd1, "R2 reserved only");
    drive(3'd1, 16'h0000, 4'd0, "R3 load zero");
    drive(3'd1, 16'h8512, 4'd0, "R3 load mixed");
    drive(3'd2, 16'hFFEA, 4'd0, "R4 ccr load");
    drive(3'd2, 16'h2015, 4'd0, "R4 ccr load 2");
    drive(3'd1, 16'hA71F, 4'd0, "R3 load live");
    drive(3'd3, 16'h0513, 4'd0, "R5 and");
    drive(3'd3, 16'hFEFF, 4'd0, "R5 and mask");
    drive(3'd4, 16'h8202, 4'd0, "R6 or");
    drive(3'd4, 16'h58EC, 4'd0, "R6 or reserved");
    drive(3'd5, 16'hFFFF, 4'd0, "R7 xor all");
    drive(3'd5, 16'h0301, 4'd0, "R7 xor mask");
    drive(3'd0, 16'hFFFF, 4'd0, "R8 op none");
    drive(3'd6, 16'h0000, 4'd0, "R8 op six");
    drive(3'd7, 16'h1234, 4'd0, "R8 op seven");

    // R11: update and condition in the same cycle
    drive(3'd1, 16'h0000, 4'd7, "R11 pre z clear");
    drive(3'd2, 16'h0004, 4'd7, "R11 set z same cycle");
    drive(3'd0, 16'h0000, 4'd7, "R11 z now visible");

    // R9 R10: all flag combinations against all selectors
    for (int f = 0; f < 32; f++) begin
      drive(3'd2, 16'(f), 4'd0, "R9 set flags");
      for (int s = 0; s < 16; s++)
        drive(3'd0, 16'h0000, 4'(s), (s < 8) ? "R9 cond sweep" : "R10 cond sweep");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule